// File: doc/BRIEF.md
# Dithered Tree Element-Balancing Encoder

This block turns a level count into the on/off pattern for a bank of equal-weight unit elements, such as the current cells of a multi-level DAC. The elements never match exactly. If the same cells were always picked for a given code, their errors would follow the signal and show up as distortion. This encoder spreads usage evenly across the bank, so the mismatch error becomes noise pushed toward high frequencies.

The selection logic is a binary tree of splitting cells. The root receives the requested level. Each cell hands half of its count to each child subtree. When its count is odd, the cell gives the extra unit to the subtree that has received fewer units so far. When both subtrees are even, the cell picks one using a pseudo-random bit. Each cell keeps a three-valued imbalance state. Because ties are broken at random, the strict alternation of a plain rotating selector cannot form. That alternation would otherwise produce spectral tones.

A pulse on the strobe input loads a new level. The enable vector updates on the next clock edge and holds until the next strobe. With the default parameters there are 16 elements, so the encoder accepts 17 codes (0 to 16).

Top module: `elem_balance_tree`

## Requirements
- R1: One clock edge after a strobe, the number of asserted bits in `en_o` equals the strobed level, with the level saturated at N.
- R2: A strobed level of 0 deasserts every element.
- R3: A strobed level of N or more asserts every element. Any value above N behaves exactly like N.
- R4: When the strobe is low, `en_o` and every cell state hold their values. Changes on `lvl_i` have no effect.
- R5: The cumulative on-counts satisfy two bounds from reset onward. For each cell, the totals of its left and right subtrees differ by at most 1. For each element pair {2j, 2j+1}, the two on-counts also differ by at most 1. The left subtree of a cell always holds the lower element indices.
- R6: After reset, N consecutive strobes of level 1 select every element exactly once.
- R7: A cell with a tied state chooses its odd unit from a free-running LFSR that advances on every clock. As a result, a single level-1 strobe after reset selects different elements depending on how many idle cycles come before it.
- R8: After reset, `en_o` is all zeros and every cell state is balanced.
- R9: Immediately after reset, a level of 2 places one element in the lower half (bits N/2-1..0) and one element in the upper half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and releases synchronously. |
| stb_i | input | 1 | Load strobe for a new level |
| lvl_i | input | LEVELS+1 | Requested level; values above N saturate |
| en_o | output | N | Element enables, registered |

## Verification
Directed patterns come first:
- Levels 0, N, N+1 and the maximum code test the saturation and empty cases.
- A run of level-1 strobes from reset shows whether the tree rotates through all elements without repeating one.
- A level-2 strobe from reset shows whether the root splits an even count between the two halves.
- Reset followed by a varying number of idle cycles separates dithered tie-breaking from a fixed rule.

Constrained random levels, some above N and with random idle gaps, then exercise the subtree-balance bound and the population count over long mixed histories. Idle cycles with a changing `lvl_i` show that nothing moves without a strobe.

// File: rtl/elem_balance_pkg.sv
package elem_balance_pkg;

  // Usage imbalance of a splitting cell: which branch has received more units.
  typedef enum logic [1:0] {
    BAL_EVEN  = 2'b00,
    BAL_LEFT  = 2'b01,
    BAL_RIGHT = 2'b10
  } bal_t;

  // Count width carried into a cell at depth d of a tree with `levels` levels.
  function automatic int unsigned ebt_cnt_w(input int unsigned levels, input int unsigned d);
    return levels - d + 1;
  endfunction

  // Bit offset of depth d inside the flat count bus (depth `levels` holds the leaves).
  function automatic int unsigned ebt_lvl_off(input int unsigned levels, input int unsigned d);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < d; j++) begin
      acc += (1 << j) * ebt_cnt_w(levels, j);
    end
    return acc;
  endfunction

endpackage

// File: rtl/ebt_rst_sync.sv
module ebt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ebt_lfsr.sv
module ebt_lfsr #(
  parameter int unsigned LFSR_W = 32,
  parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2469,
  parameter int unsigned RND_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] rnd_o
);

  logic [LFSR_W-1:0] st_q;
  logic [LFSR_W-1:0] st_nxt;

  // Galois step, free running.
  always_comb begin
    st_nxt = st_q >> 1;
    if (st_q[0]) begin
      st_nxt = st_nxt ^ TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else begin
      st_q <= st_nxt;
    end
  end

  // Fold every state bit onto the per-cell random vector.
  always_comb begin
    rnd_o = '0;
    for (int unsigned j = 0; j < LFSR_W; j++) begin
      rnd_o[j % RND_W] = rnd_o[j % RND_W] ^ st_q[j];
    end
  end

endmodule

// File: rtl/ebt_split_node.sv
module ebt_split_node
  import elem_balance_pkg::*;
#(
  parameter int unsigned IN_W = 5,
  localparam int unsigned OUT_W = IN_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             rnd_i,
  input  logic [IN_W-1:0]  cnt_i,
  output logic [OUT_W-1:0] cnt_l_o,
  output logic [OUT_W-1:0] cnt_r_o
);

  bal_t             st_q;
  bal_t             st_nxt;
  logic             odd;
  logic             give_left;
  logic [OUT_W-1:0] half;

  assign half = cnt_i[IN_W-1:1];
  assign odd  = cnt_i[0];

  // The odd unit goes to the branch that is behind; a tie uses the random bit.
  always_comb begin
    case (st_q)
      BAL_LEFT:  give_left = 1'b0;
      BAL_RIGHT: give_left = 1'b1;
      default:   give_left = rnd_i;
    endcase
  end

  assign cnt_l_o = half + OUT_W'(odd & give_left);
  assign cnt_r_o = half + OUT_W'(odd & ~give_left);

  always_comb begin
    st_nxt = st_q;
    if (odd) begin
      case (st_q)
        BAL_LEFT:  st_nxt = BAL_EVEN;
        BAL_RIGHT: st_nxt = BAL_EVEN;
        default:   st_nxt = give_left ? BAL_LEFT : BAL_RIGHT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BAL_EVEN;
    end else if (upd_en) begin
      st_q <= st_nxt;
    end
  end

endmodule

// File: rtl/elem_balance_tree.sv
module elem_balance_tree
  import elem_balance_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned LFSR_W = 32,
  localparam int unsigned N      = 1 << LEVELS,
  localparam int unsigned CNT_W  = LEVELS + 1,
  localparam int unsigned NODES  = N - 1,
  localparam int unsigned BUS_W  = ebt_lvl_off(LEVELS, LEVELS + 1),
  localparam int unsigned LEAF_O = ebt_lvl_off(LEVELS, LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [CNT_W-1:0] lvl_i,
  output logic [N-1:0]     en_o
);

  logic             rst_sync_n;
  logic [NODES-1:0] rnd;
  logic [BUS_W-1:0] tree_bus;
  logic [CNT_W-1:0] lvl_sat;
  logic [N-1:0]     en_nxt;
  logic [N-1:0]     en_q;

  ebt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ebt_lfsr #(
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_W'(32'h8020_0003)),
    .SEED   (LFSR_W'(32'hACE1_2469)),
    .RND_W  (NODES)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rnd_o (rnd)
  );

  // Saturate the request at the element count.
  assign lvl_sat = (lvl_i > CNT_W'(N)) ? CNT_W'(N) : lvl_i;
  assign tree_bus[CNT_W-1:0] = lvl_sat;

  for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
    localparam int unsigned IW   = ebt_cnt_w(LEVELS, d);
    localparam int unsigned OW   = IW - 1;
    localparam int unsigned IOFF = ebt_lvl_off(LEVELS, d);
    localparam int unsigned OOFF = ebt_lvl_off(LEVELS, d + 1);
    for (genvar i = 0; i < (1 << d); i++) begin : g_node
      ebt_split_node #(
        .IN_W (IW)
      ) u_node (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .upd_en  (stb_i),
        .rnd_i   (rnd[(1 << d) - 1 + i]),
        .cnt_i   (tree_bus[IOFF + i*IW +: IW]),
        .cnt_l_o (tree_bus[OOFF + (2*i)*OW +: OW]),
        .cnt_r_o (tree_bus[OOFF + (2*i+1)*OW +: OW])
      );
    end
  end

  assign en_nxt = tree_bus[LEAF_O +: N];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q <= '0;
    end else if (stb_i) begin
      en_q <= en_nxt;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/elem_balance_tree_chk.sv
module elem_balance_tree_chk #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned LFSR_W = 32,
  localparam int unsigned N     = 1 << LEVELS,
  localparam int unsigned CNT_W = LEVELS + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb_i,
  input logic [CNT_W-1:0] lvl_i,
  input logic [N-1:0]     en_o
);

  logic [2:0]       arm_q;
  logic             armed;
  logic             stb_d;
  logic [CNT_W-1:0] want;

  // Covers the reset synchronizer inside the block.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      stb_d <= 1'b0;
    end else begin
      arm_q <= {arm_q[1:0], 1'b1};
      stb_d <= stb_i & arm_q[2];
    end
  end
  assign armed = arm_q[2];
  assign want  = (lvl_i > CNT_W'(N)) ? CNT_W'(N) : lvl_i;

  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && $past(stb_i) |-> $countones(en_o) == int'($past(want)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && $past(stb_i) && $past(lvl_i) == '0 |-> en_o == '0);

  p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && $past(stb_i) && $past(lvl_i) >= CNT_W'(N) |-> &en_o);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(armed) && !$past(stb_i) |-> $stable(en_o));

  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> en_o == '0);

  // Pair balance: running difference of on-counts per element pair.
  for (genvar j = 0; j < N/2; j++) begin : g_pair
    logic signed [2:0] diff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        diff_q <= '0;
      end else if (stb_d) begin
        diff_q <= diff_q + $signed({2'b00, en_o[2*j]}) - $signed({2'b00, en_o[2*j+1]});
      end
    end
    p_pair_bal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      diff_q >= -3'sd1 && diff_q <= 3'sd1);
  end

endmodule

bind elem_balance_tree elem_balance_tree_chk #(.LEVELS(LEVELS), .LFSR_W(LFSR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .stb_i (stb_i),
  .lvl_i (lvl_i),
  .en_o  (en_o)
);

// File: tb/elem_balance_tree_tb.sv
module elem_balance_tree_tb;

  localparam int unsigned LEVELS = 4;
  localparam int unsigned N      = 1 << LEVELS;
  localparam int unsigned CNT_W  = LEVELS + 1;

  logic             clk;
  logic             rst_n;
  logic             stb_i;
  logic [CNT_W-1:0] lvl_i;
  logic [N-1:0]     en_o;

  int n_chk;
  int n_fail;
  int use_cnt [N];
  bit reported;

  elem_balance_tree #(.LEVELS(LEVELS)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (stb_i),
    .lvl_i (lvl_i),
    .en_o  (en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int sat(input int v);
    return (v > int'(N)) ? int'(N) : v;
  endfunction

  function automatic int pop(input logic [N-1:0] v);
    int c = 0;
    for (int k = 0; k < int'(N); k++) c += int'(v[k]);
    return c;
  endfunction

  // Largest subtree imbalance over all cells of the tree.
  function automatic int worst_imbalance();
    int worst = 0;
    for (int d = 0; d < int'(LEVELS); d++) begin
      int span = int'(N) >> d;
      for (int i = 0; i < (1 << d); i++) begin
        int l = 0;
        int r = 0;
        for (int k = 0; k < span/2; k++) begin
          l += use_cnt[i*span + k];
          r += use_cnt[i*span + span/2 + k];
        end
        if (l - r > worst) worst = l - r;
        if (r - l > worst) worst = r - l;
      end
    end
    return worst;
  endfunction

  task automatic do_reset(input int idle);
    @(negedge clk);
    rst_n = 1'b0;
    stb_i = 1'b0;
    lvl_i = '0;
    for (int k = 0; k < int'(N); k++) use_cnt[k] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3 + idle) @(negedge clk);
  endtask

  // Strobe a level; returns the enables seen after the capturing edge.
  task automatic do_strobe(input int lvl, output logic [N-1:0] seen);
    @(negedge clk);
    stb_i = 1'b1;
    lvl_i = CNT_W'(lvl);
    @(negedge clk);
    stb_i = 1'b0;
    seen = en_o;
    for (int k = 0; k < int'(N); k++) use_cnt[k] += int'(seen[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [N-1:0] seen;
    logic [N-1:0] held;
    logic [N-1:0] mask;
    void'($urandom(32'd7351));
    n_chk = 0;
    n_fail = 0;
    reported = 1'b0;
    rst_n = 1'b0;
    stb_i = 1'b0;
    lvl_i = '0;

    // R8: reset state
    do_reset(0);
    check(en_o == '0, "R8 reset enables", longint'(en_o), 0);

    // R9: even count split at the root right after reset
    do_strobe(2, seen);
    check(pop(seen[N/2-1:0]) == 1 && pop(seen[N-1:N/2]) == 1, "R9 halves",
          longint'(seen), 0);

    // R6: N level-1 strobes cover each element once
    do_reset(1);
    mask = '0;
    for (int s = 0; s < int'(N); s++) begin
      do_strobe(1, seen);
      check(pop(seen) == 1, "R1 single", pop(seen), 1);
      mask = mask | seen;
    end
    check(&mask, "R6 full rotation", longint'(mask), longint'({N{1'b1}}));
    for (int k = 0; k < int'(N); k++)
      check(use_cnt[k] == 1, "R6 element used once", use_cnt[k], 1);

    // R4: no strobe, changing lvl_i has no effect
    do_strobe(5, seen);
    held = seen;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      lvl_i = CNT_W'($urandom_range(0, 31));
      check(en_o == held, "R4 hold", longint'(en_o), longint'(held));
    end

    // R2 and R3: empty and saturated codes
    do_strobe(0, seen);
    check(seen == '0, "R2 zero", longint'(seen), 0);
    do_strobe(int'(N), seen);
    check(&seen, "R3 full", longint'(seen), longint'({N{1'b1}}));
    do_strobe(int'(N) + 1, seen);
    check(&seen, "R3 over", longint'(seen), longint'({N{1'b1}}));
    do_strobe(31, seen);
    check(&seen, "R3 max code", longint'(seen), longint'({N{1'b1}}));
    check(worst_imbalance() <= 1, "R5 balance", worst_imbalance(), 1);

    // R7: tie break depends on idle cycles since reset
    mask = '0;
    for (int t = 0; t < 16; t++) begin
      do_reset(t);
      do_strobe(1, seen);
      mask = mask | seen;
    end
    check(pop(mask) >= 2, "R7 dithered tie", pop(mask), 2);

    // Random traffic: R1 population and R5 balance
    do_reset(0);
    for (int s = 0; s < 2000; s++) begin
      int lvl;
      int gap;
      lvl = $urandom_range(0, 20);
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      do_strobe(lvl, seen);
      check(pop(seen) == sat(lvl), "R1 population", pop(seen), sat(lvl));
      check(worst_imbalance() <= 1, "R5 subtree balance", worst_imbalance(), 1);
    end

    finish_run();
  end

endmodule